// File: doc/BRIEF.md
# Attenuation State Mode Selector

This block owns the seven-bit control code that sets a switched step attenuator. The code is a plain binary count of quarter-decibel steps: bit i carries a weight of 0.25 dB times 2^i, so the top bit is worth 16 dB and the code equals four times the wanted attenuation (18.25 dB is code 73, hex 49). One output register is loaded from three sources. The first is a transparent parallel path, used while the latch-enable pin is high. The second is a captured parallel path, which takes the data on the high-to-low transition of latch enable. The third is a path fed by an upstream serial receiver, which has already done the address matching and hands over one eight-bit word per update strobe.

After reset the code is all ones, the largest attenuation. In the transparent parallel case the block keeps that value for a programmable number of clock cycles before it lets the pins through. This gives the analog array a defined start-up interval. Changing the path-select pin never changes the code by itself. The code moves only when the newly selected path produces an update.

The serial word interface is a strobe only. A word is consumed in the cycle its valid is high. The block never exerts back-pressure, so the receiver needs no ready signal and may present a word on any cycle.

Top module: `atten_mode_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `atten_q` is 7'h7F. It stays there until a word is accepted or, in the transparent parallel case, until the start-up window ends.
- R2: With `ser_sel` = 0 and `latch_en` low in both the current and the previous cycle, `atten_q` holds its value whatever `par_data` does.
- R3: With `ser_sel` = 0, the first cycle in which `latch_en` is low after being high loads `par_data` of that cycle into `atten_q` at the next clock edge. This holds during the start-up window as well.
- R4: With `ser_sel` = 0 and `latch_en` high after the start-up window, `atten_q` takes the `par_data` value of each cycle one clock edge later.
- R5: With `ser_sel` = 0 and `latch_en` high, `atten_q` stays 7'h7F for the first `PUP_CYCLES` clock edges after reset release. It takes `par_data` at edge `PUP_CYCLES`+1.
- R6: With `ser_sel` = 1, a cycle with `ser_valid` high and `ser_word[7]` = 0 loads `ser_word[6:0]` into `atten_q` at the next edge.
- R7: With `ser_sel` = 1, a word with `ser_word[7]` = 1 is rejected and `atten_q` keeps its value.
- R8: With `ser_sel` = 0, `ser_valid` has no effect on `atten_q`. With `ser_sel` = 1, `par_data` and `latch_en` (including its falling edge) have no effect on `atten_q`.
- R9: A change of `ser_sel` leaves `atten_q` unchanged until an update of the newly selected path. A serial strobe in the same cycle that `ser_sel` falls is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel | input | 1 | Path select: 0 parallel, 1 serial |
| latch_en | input | 1 | High: transparent parallel; high-to-low: capture |
| par_data | input | 7 | Parallel attenuation code |
| ser_valid | input | 1 | Serial word strobe |
| ser_word | input | 8 | Serial word; bit 7 must be 0, bits 6:0 the code |
| atten_q | output | 7 | Registered attenuation code |

## Verification
Two events can land in one cycle. The first pair is the path-select falling while the serial receiver strobes a word. The bench drives both in the same cycle and expects the code to hold, since the strobe belongs to a path that is no longer selected. The second pair is a latch-enable pulse falling inside the start-up window. There the transparent update is still blocked but a capture must go through. The bench pulses latch enable during that window and expects all ones while it is high and the captured data after it falls.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int ATTEN_BITS = 7;
  localparam int WORD_BITS  = 8;

  typedef enum logic [1:0] {
    MODE_DIRECT  = 2'd0,
    MODE_LATCHED = 2'd1,
    MODE_SERIAL  = 2'd2
  } atten_mode_e;

  function automatic atten_mode_e decode_mode(input logic ser_sel, input logic latch_en);
    if (ser_sel)       return MODE_SERIAL;
    else if (latch_en) return MODE_DIRECT;
    else               return MODE_LATCHED;
  endfunction
endpackage

// File: rtl/atten_pup_timer.sv
module atten_pup_timer #(
  parameter int PUP_CYCLES = 40000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  generate
    if (PUP_CYCLES == 0) begin : g_none
      assign done = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(PUP_CYCLES + 1);
      localparam logic [CW-1:0] LIMIT = CW'(PUP_CYCLES);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (cnt != LIMIT)   cnt <= cnt + 1'b1;
      end
      assign done = (cnt == LIMIT);
    end
  endgenerate
endmodule

// File: rtl/atten_le_edge.sv
module atten_le_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic latch_en,
  output logic le_fall
);
  logic le_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) le_d <= 1'b0;
    else        le_d <= latch_en;
  end
  assign le_fall = le_d & ~latch_en;
endmodule

// File: rtl/atten_ser_filter.sv
module atten_ser_filter #(
  parameter int ATTEN_W = 7,
  parameter int WORD_W  = 8
) (
  input  logic               sel,
  input  logic               valid,
  input  logic [WORD_W-1:0]  word,
  output logic               accept,
  output logic [ATTEN_W-1:0] code
);
  localparam int GUARD_W = WORD_W - ATTEN_W;
  logic guard_clear;

  generate
    if (GUARD_W > 0) begin : g_guard
      assign guard_clear = ~|word[WORD_W-1:ATTEN_W];
    end else begin : g_noguard
      assign guard_clear = 1'b1;
    end
  endgenerate

  assign accept = sel & valid & guard_clear;
  assign code   = word[ATTEN_W-1:0];
endmodule

// File: rtl/atten_par_path.sv
module atten_par_path #(
  parameter int ATTEN_W = 7
) (
  input  atten_pkg::atten_mode_e mode,
  input  logic                   pup_done,
  input  logic                   le_fall,
  input  logic [ATTEN_W-1:0]     par_data,
  output logic                   load,
  output logic [ATTEN_W-1:0]     code
);
  import atten_pkg::*;
  always_comb begin
    unique case (mode)
      MODE_DIRECT:  load = pup_done;
      MODE_LATCHED: load = le_fall;
      default:      load = 1'b0;
    endcase
  end
  assign code = par_data;
endmodule

// File: rtl/atten_mode_ctrl.sv
module atten_mode_ctrl #(
  parameter int PUP_CYCLES = 40000,
  parameter int ATTEN_W    = atten_pkg::ATTEN_BITS,
  parameter int WORD_W     = atten_pkg::WORD_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_sel,
  input  logic               latch_en,
  input  logic [ATTEN_W-1:0] par_data,
  input  logic               ser_valid,
  input  logic [WORD_W-1:0]  ser_word,
  output logic [ATTEN_W-1:0] atten_q
);
  import atten_pkg::*;

  localparam logic [ATTEN_W-1:0] CODE_MAX = '1;

  atten_mode_e        mode;
  logic               pup_done;
  logic               le_fall;
  logic               par_load, ser_accept;
  logic [ATTEN_W-1:0] par_code, ser_code;

  assign mode = decode_mode(ser_sel, latch_en);

  atten_pup_timer #(.PUP_CYCLES(PUP_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .done(pup_done)
  );

  atten_le_edge u_edge (
    .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .le_fall(le_fall)
  );

  atten_par_path #(.ATTEN_W(ATTEN_W)) u_par (
    .mode(mode), .pup_done(pup_done), .le_fall(le_fall),
    .par_data(par_data), .load(par_load), .code(par_code)
  );

  atten_ser_filter #(.ATTEN_W(ATTEN_W), .WORD_W(WORD_W)) u_ser (
    .sel(ser_sel), .valid(ser_valid), .word(ser_word),
    .accept(ser_accept), .code(ser_code)
  );

  // Parallel and serial loads are exclusive through ser_sel.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          atten_q <= CODE_MAX;
    else if (par_load)   atten_q <= par_code;
    else if (ser_accept) atten_q <= ser_code;
  end
endmodule

// File: rtl/atten_mode_ctrl_chk.sv
module atten_mode_ctrl_chk #(
  parameter int PUP_CYCLES = 40000,
  parameter int ATTEN_W    = 7,
  parameter int WORD_W     = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ser_sel,
  input logic               latch_en,
  input logic [ATTEN_W-1:0] par_data,
  input logic               ser_valid,
  input logic [WORD_W-1:0]  ser_word,
  input logic [ATTEN_W-1:0] atten_q
);
  localparam int CW = $clog2(PUP_CYCLES + 2);
  localparam logic [CW-1:0] LIMIT = CW'(PUP_CYCLES);

  logic [CW-1:0] since_rst;
  logic          le_seen;
  logic          first_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      le_seen   <= 1'b0;
      first_cyc <= 1'b1;
    end else begin
      if (since_rst < LIMIT) since_rst <= since_rst + 1'b1;
      le_seen   <= latch_en;
      first_cyc <= 1'b0;
    end
  end

  wire win_open = (since_rst < LIMIT);
  wire bad_word = |ser_word[WORD_W-1:ATTEN_W];

  p_reset_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
    first_cyc |-> (atten_q == '1));

  p_latched_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_sel && !latch_en && !le_seen) |=> $stable(atten_q));

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_sel && !latch_en && le_seen) |=> (atten_q == $past(par_data)));

  p_direct_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_sel && latch_en && !win_open) |=> (atten_q == $past(par_data)));

  p_window_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_sel && latch_en && win_open) |=> $stable(atten_q));

  p_serial_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_sel && ser_valid && !bad_word) |=> (atten_q == $past(ser_word[ATTEN_W-1:0])));

  p_serial_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_sel && ser_valid && bad_word) |=> $stable(atten_q));

  p_serial_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_sel && !ser_valid) |=> $stable(atten_q));
endmodule

bind atten_mode_ctrl atten_mode_ctrl_chk #(
  .PUP_CYCLES(PUP_CYCLES), .ATTEN_W(ATTEN_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .latch_en(latch_en),
  .par_data(par_data), .ser_valid(ser_valid), .ser_word(ser_word),
  .atten_q(atten_q)
);

// File: tb/atten_mode_ctrl_bench.sv
`timescale 1ns/1ps
module atten_mode_ctrl_bench;
  localparam int PUP = 20;
  localparam int NV  = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_sel = 1'b0, latch_en = 1'b1, ser_valid = 1'b0;
  logic [6:0] par_data = '0;
  logic [7:0] ser_word = '0;
  logic [6:0] atten_q;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  atten_mode_ctrl #(.PUP_CYCLES(PUP)) u_atten_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .latch_en(latch_en),
    .par_data(par_data), .ser_valid(ser_valid), .ser_word(ser_word),
    .atten_q(atten_q)
  );

  // {ser_sel, latch_en, par_data, ser_valid, ser_word, expected, req}
  localparam logic [28:0] VEC [NV] = '{
    {1'b0,1'b1,7'h22,1'b0,8'h00,7'h22,4'd4},  // R4 transparent
    {1'b0,1'b1,7'h49,1'b0,8'h00,7'h49,4'd4},  // R4 18.25 dB = 73
    {1'b0,1'b0,7'h49,1'b0,8'h00,7'h49,4'd3},  // R3 fall captures
    {1'b0,1'b0,7'h0A,1'b0,8'h00,7'h49,4'd2},  // R2 hold
    {1'b0,1'b1,7'h33,1'b0,8'h00,7'h33,4'd4},  // R4
    {1'b0,1'b0,7'h33,1'b0,8'h00,7'h33,4'd3},  // R3
    {1'b0,1'b0,7'h7E,1'b0,8'h00,7'h33,4'd2},  // R2
    {1'b0,1'b0,7'h01,1'b1,8'h05,7'h33,4'd8},  // R8 strobe ignored
    {1'b1,1'b0,7'h01,1'b0,8'h00,7'h33,4'd9},  // R9 switch holds
    {1'b1,1'b1,7'h55,1'b0,8'h00,7'h33,4'd8},  // R8 pins ignored
    {1'b1,1'b0,7'h55,1'b1,8'h2A,7'h2A,4'd6},  // R6
    {1'b1,1'b0,7'h55,1'b1,8'hAA,7'h2A,4'd7},  // R7
    {1'b1,1'b0,7'h55,1'b1,8'h7F,7'h7F,4'd6},  // R6
    {1'b1,1'b0,7'h55,1'b1,8'h00,7'h00,4'd6},  // R6
    {1'b1,1'b0,7'h55,1'b1,8'h80,7'h00,4'd7},  // R7
    {1'b0,1'b0,7'h11,1'b1,8'h06,7'h00,4'd9},  // R9 switch + strobe
    {1'b0,1'b1,7'h11,1'b0,8'h00,7'h11,4'd9},  // R9 new-path update
    {1'b1,1'b1,7'h11,1'b0,8'h00,7'h11,4'd9},  // R9
    {1'b1,1'b0,7'h22,1'b0,8'h00,7'h11,4'd8},  // R8 fall in serial
    {1'b0,1'b0,7'h40,1'b0,8'h00,7'h11,4'd9}   // R9 into capture path
  };

  task automatic check(input logic [6:0] exp, input int req, input string what);
    checks++;
    if (atten_q !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, atten_q, exp);
    end
  endtask

  task automatic drive(input logic s, input logic le, input logic [6:0] p,
                       input logic v, input logic [7:0] w);
    ser_sel = s; latch_en = le; par_data = p; ser_valid = v; ser_word = w;
  endtask

  task automatic do_reset(input logic s, input logic le, input logic [6:0] p);
    @(negedge clk);
    rst_n = 1'b0;
    drive(s, le, p, 1'b0, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 and R5: transparent case, start-up window
    do_reset(1'b0, 1'b1, 7'h15);
    check(7'h7F, 1, "value after reset");
    repeat (PUP) @(negedge clk);
    check(7'h7F, 5, "held through window");
    @(negedge clk);
    check(7'h15, 5, "pins taken after window");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][28], VEC[i][27], VEC[i][26:20], VEC[i][19], VEC[i][18:11]);
      @(negedge clk);
      check(VEC[i][10:4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
    end

    // R1, R5, R3: capture path after reset, pulse inside the window
    do_reset(1'b0, 1'b0, 7'h0C);
    @(negedge clk);
    drive(1'b0, 1'b0, 7'h70, 1'b0, 8'h00);
    @(negedge clk);
    check(7'h7F, 1, "capture path holds max after reset");
    drive(1'b0, 1'b1, 7'h70, 1'b0, 8'h00);
    @(negedge clk);
    check(7'h7F, 5, "transparent blocked in window");
    drive(1'b0, 1'b0, 7'h70, 1'b0, 8'h00);
    @(negedge clk);
    check(7'h70, 3, "capture inside window");

    // R1, R7, R6: serial path after reset
    do_reset(1'b1, 1'b0, 7'h00);
    repeat (3) @(negedge clk);
    check(7'h7F, 1, "serial path holds max after reset");
    drive(1'b1, 1'b0, 7'h00, 1'b1, 8'h85);
    @(negedge clk);
    check(7'h7F, 7, "top bit set rejected");
    drive(1'b1, 1'b0, 7'h00, 1'b1, 8'h03);
    @(negedge clk);
    check(7'h03, 6, "serial load");
    drive(1'b1, 1'b0, 7'h00, 1'b0, 8'h44);
    @(negedge clk);
    check(7'h03, 8, "no strobe no change");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule